// File: doc/BRIEF.md
# Deferred-Start Frame Transmit Controller

This block decides when the bytes of a frame leave a transmit FIFO and reach a serial framer. The host sets the frame length and the operating mode through a small register port. In immediate mode a frame begins as soon as the FIFO holds a byte. In deferred mode the host first fills the FIFO with part or all of a frame. The frame then begins only when the host issues a start command. This lets short frames be queued whole before the line starts, so they cannot run dry.

If the FIFO runs empty before the programmed number of bytes has gone out, the block tells the framer to close the frame with an inverted checksum, so the far end rejects the frame. The block then blocks all further sending. Sending resumes only after the host has done two things since that event: flushed the FIFO and read the resume register. The two steps may come in either order.

A configuration bit replaces this underrun handling with line stretching. While the FIFO is empty mid-frame, the framer is told to extend the stop condition, and the frame continues when data arrives. The bit-level encoder and the checksum arithmetic live in the framer.

Top module: `dstx_ctrl`

## Requirements
- R1: After a synchronous reset, `fr_valid`, `fr_stretch`, `fifo_flush`, `fifo_rd` and `tx_locked` are all 0, and immediate mode is selected.
- R2: In immediate mode (register 0 bit 0 clear), a frame starts as soon as the FIFO is non-empty and the length (register 1) is non-zero. Its bytes reach the framer in FIFO order with `fr_op` 0, except the final byte, which carries `fr_op` 1.
- R3: In deferred mode (register 0 bit 0 set), no byte is read or presented until the host writes 1 to bit 0 of the command register (register 2).
- R4: The start command is a one-shot pulse. A start written while a frame is in progress is discarded and does not launch a later frame.
- R5: While `fr_valid` is high and `fr_ready` is low, `fr_valid`, `fr_op` and `fr_data` hold their values.
- R6: If the FIFO is empty when the next byte of a frame is due and stretching is off, the block presents a close item with `fr_op` 2 and `fr_data` 0, telling the framer to append the inverted checksum. It then raises `tx_locked`.
- R7: While `tx_locked` is high, the FIFO is not read and no item is presented.
- R8: `tx_locked` falls only after both of these have happened since the underrun: a FIFO flush (command register bit 1, seen as a `fifo_flush` pulse) and a read of register 3. Either order works, and either step alone leaves the block locked.
- R9: With stretching on (register 0 bit 1 set), an empty FIFO mid-frame raises `fr_stretch` with `fr_valid` low and no lockout. The frame continues in order once data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 2 | Register select: 0 mode, 1 length, 2 command, 3 resume |
| host_wdata | input | HOST_W | Host write data |
| fifo_empty | input | 1 | Transmit FIFO empty flag |
| fifo_data | input | DATA_W | Head byte of the FIFO (show-ahead) |
| fifo_rd | output | 1 | Pop strobe for the FIFO head |
| fifo_flush | output | 1 | One-cycle FIFO clear request |
| fr_ready | input | 1 | Framer accepts the presented item |
| fr_valid | output | 1 | Item presented to the framer |
| fr_op | output | 2 | 0 byte, 1 final byte, 2 close with inverted checksum |
| fr_data | output | DATA_W | Byte for the framer |
| fr_stretch | output | 1 | Extend the stop condition while data is missing |
| tx_locked | output | 1 | Underrun lockout status |

## Verification
The bench builds the block with a 4-bit length field and 8-bit data. With these values, short frames of two to five bytes are enough to drive every path: a clean finish, a mid-frame underrun, a stall under backpressure, and a stretch gap. Both recovery orders are exercised. One run also includes a stale resume read issued before the underrun, to show that it does not count toward recovery.

// File: rtl/dstx_pkg.sv
package dstx_pkg;
  typedef enum logic [1:0] {
    OP_DATA  = 2'd0,
    OP_LAST  = 2'd1,
    OP_ABORT = 2'd2
  } fr_op_t;

  localparam logic [1:0] ADDR_MODE   = 2'd0;
  localparam logic [1:0] ADDR_LEN    = 2'd1;
  localparam logic [1:0] ADDR_CMD    = 2'd2;
  localparam logic [1:0] ADDR_RESUME = 2'd3;
endpackage

// File: rtl/dstx_regs.sv
module dstx_regs
  import dstx_pkg::*;
#(
  parameter int HOST_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  output logic              defer_en,
  output logic              stretch_en,
  output logic [LEN_W-1:0]  frame_len,
  output logic              start_req,
  output logic              fifo_flush,
  output logic              resume_rd
);
  logic unused_wdata;
  assign unused_wdata = ^host_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      defer_en   <= 1'b0;
      stretch_en <= 1'b0;
      frame_len  <= '0;
      start_req  <= 1'b0;
      fifo_flush <= 1'b0;
      resume_rd  <= 1'b0;
    end else begin
      start_req  <= 1'b0;
      fifo_flush <= 1'b0;
      resume_rd  <= host_rd && (host_addr == ADDR_RESUME);
      if (host_wr) begin
        case (host_addr)
          ADDR_MODE: begin
            defer_en   <= host_wdata[0];
            stretch_en <= host_wdata[1];
          end
          ADDR_LEN: frame_len <= host_wdata[LEN_W-1:0];
          ADDR_CMD: begin
            start_req  <= host_wdata[0];
            fifo_flush <= host_wdata[1];
          end
          default: ;
        endcase
      end
    end
  end

  a_r4_start_one_shot: assert property (@(posedge clk) disable iff (rst)
    start_req |=> (!start_req || $past(host_wr)));
endmodule

// File: rtl/dstx_lock.sv
module dstx_lock (
  input  logic clk,
  input  logic rst,
  input  logic underrun,
  input  logic flush_seen,
  input  logic resume_seen,
  output logic locked
);
  logic got_flush, got_resume;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked     <= 1'b0;
      got_flush  <= 1'b0;
      got_resume <= 1'b0;
    end else if (underrun) begin
      locked     <= 1'b1;
      got_flush  <= 1'b0;
      got_resume <= 1'b0;
    end else if (locked) begin
      if ((got_flush || flush_seen) && (got_resume || resume_seen)) begin
        locked     <= 1'b0;
        got_flush  <= 1'b0;
        got_resume <= 1'b0;
      end else begin
        got_flush  <= got_flush  || flush_seen;
        got_resume <= got_resume || resume_seen;
      end
    end
  end

  a_r8_needs_resume: assert property (@(posedge clk) disable iff (rst)
    (locked && !got_resume && !resume_seen) |=> locked);
  a_r8_needs_flush: assert property (@(posedge clk) disable iff (rst)
    (locked && !got_flush && !flush_seen) |=> locked);
endmodule

// File: rtl/dstx_seq.sv
module dstx_seq
  import dstx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              defer_en,
  input  logic              stretch_en,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              start_req,
  input  logic              locked,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fr_ready,
  output logic              fifo_rd,
  output logic              fr_valid,
  output fr_op_t            fr_op,
  output logic [DATA_W-1:0] fr_data,
  output logic              fr_stretch,
  output logic              underrun
);
  typedef enum logic {S_IDLE, S_RUN} seq_state_t;

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  seq_state_t       st;
  logic [LEN_W-1:0] remain;
  logic             pend;
  logic             slot_free;
  logic             go;

  assign slot_free = !fr_valid || fr_ready;
  assign go        = !locked && (frame_len != '0) &&
                     (defer_en ? pend : !fifo_empty);
  assign fifo_rd   = (st == S_RUN) && slot_free && !fifo_empty;
  assign underrun  = (st == S_RUN) && slot_free && fifo_empty && !stretch_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      remain     <= '0;
      pend       <= 1'b0;
      fr_valid   <= 1'b0;
      fr_op      <= OP_DATA;
      fr_data    <= '0;
      fr_stretch <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          fr_stretch <= 1'b0;
          if (slot_free) fr_valid <= 1'b0;
          if (go) begin
            st     <= S_RUN;
            remain <= frame_len;
            pend   <= 1'b0;
          end else if (!defer_en) begin
            pend <= 1'b0;
          end else if (start_req && !locked) begin
            pend <= 1'b1;
          end
        end
        default: begin
          if (slot_free) begin
            if (!fifo_empty) begin
              fr_valid   <= 1'b1;
              fr_data    <= fifo_data;
              fr_op      <= (remain == ONE) ? OP_LAST : OP_DATA;
              fr_stretch <= 1'b0;
              remain     <= remain - ONE;
              if (remain == ONE) st <= S_IDLE;
            end else if (stretch_en) begin
              fr_valid   <= 1'b0;
              fr_stretch <= 1'b1;
            end else begin
              fr_valid   <= 1'b1;
              fr_data    <= '0;
              fr_op      <= OP_ABORT;
              fr_stretch <= 1'b0;
              st         <= S_IDLE;
            end
          end
        end
      endcase
    end
  end

  a_r5_hold_item: assert property (@(posedge clk) disable iff (rst)
    (fr_valid && !fr_ready) |=> (fr_valid && $stable(fr_data) && $stable(fr_op)));
  a_r3_start_after_cmd: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == S_IDLE && st == S_RUN && $past(defer_en)) |-> $past(pend));
  a_r6_abort_follows: assert property (@(posedge clk) disable iff (rst)
    underrun |=> (fr_valid && fr_op == OP_ABORT));
  a_r9_stretch_quiet: assert property (@(posedge clk) disable iff (rst)
    fr_stretch |-> !fr_valid);
endmodule

// File: rtl/dstx_ctrl.sv
module dstx_ctrl
  import dstx_pkg::*;
#(
  parameter int HOST_W = 8,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_rd,
  output logic              fifo_flush,
  input  logic              fr_ready,
  output logic              fr_valid,
  output logic [1:0]        fr_op,
  output logic [DATA_W-1:0] fr_data,
  output logic              fr_stretch,
  output logic              tx_locked
);
  logic             defer_en, stretch_en, start_req, resume_rd, underrun;
  logic [LEN_W-1:0] frame_len;
  fr_op_t           op_q;

  dstx_regs #(.HOST_W(HOST_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .defer_en(defer_en), .stretch_en(stretch_en), .frame_len(frame_len),
    .start_req(start_req), .fifo_flush(fifo_flush), .resume_rd(resume_rd)
  );

  dstx_lock u_lock (
    .clk(clk), .rst(rst), .underrun(underrun),
    .flush_seen(fifo_flush), .resume_seen(resume_rd), .locked(tx_locked)
  );

  dstx_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .defer_en(defer_en), .stretch_en(stretch_en),
    .frame_len(frame_len), .start_req(start_req), .locked(tx_locked),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fr_ready(fr_ready),
    .fifo_rd(fifo_rd), .fr_valid(fr_valid), .fr_op(op_q), .fr_data(fr_data),
    .fr_stretch(fr_stretch), .underrun(underrun)
  );

  assign fr_op = op_q;

  a_r7_no_pop_locked: assert property (@(posedge clk) disable iff (rst)
    tx_locked |-> !fifo_rd);
  a_r7_locked_after_abort: assert property (@(posedge clk) disable iff (rst)
    (fr_valid && fr_op == 2'd2) |-> tx_locked);
endmodule

// File: tb/test_dstx_ctrl.sv
module test_dstx_ctrl;
  localparam int HOST_W = 8;
  localparam int DATA_W = 8;
  localparam int LEN_W  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0] host_addr = '0;
  logic [HOST_W-1:0] host_wdata = '0;
  logic fifo_empty, fifo_rd, fifo_flush;
  logic [DATA_W-1:0] fifo_data;
  logic fr_ready = 1'b1;
  logic fr_valid, fr_stretch, tx_locked;
  logic [1:0] fr_op;
  logic [DATA_W-1:0] fr_data;

  always #4 clk = ~clk;

  dstx_ctrl #(.HOST_W(HOST_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) i_dstx_ctrl (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
    .fifo_flush(fifo_flush), .fr_ready(fr_ready), .fr_valid(fr_valid),
    .fr_op(fr_op), .fr_data(fr_data), .fr_stretch(fr_stretch),
    .tx_locked(tx_locked)
  );

  logic [DATA_W-1:0] mem [0:63];
  logic [6:0] wp = '0, rp = '0;
  assign fifo_empty = (wp == rp);
  assign fifo_data  = mem[rp[5:0]];
  always @(posedge clk) begin
    if (fifo_flush) rp <= wp;
    else if (fifo_rd) rp <= rp + 7'd1;
  end

  int total = 0, bad = 0, n_hs = 0;
  logic [9:0] exp_q [$];
  string      tag_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && fr_valid && fr_ready) begin
      n_hs++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected item", {fr_op, fr_data}, 0);
      end else begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({fr_op, fr_data} == e, t, {fr_op, fr_data}, e);
      end
    end
  end

  task automatic expect_item(input logic [1:0] op, input logic [7:0] d, input string t);
    exp_q.push_back({op, d});
    tag_q.push_back(t);
  endtask

  task automatic push(input logic [7:0] d);
    mem[wp[5:0]] = d;
    wp = wp + 7'd1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic rd_resume();
    @(posedge clk); #1;
    host_rd = 1'b1; host_addr = 2'd3;
    @(posedge clk); #1;
    host_rd = 1'b0;
  endtask

  task automatic drain(input string t);
    for (int i = 0; i < 300 && exp_q.size() != 0; i++) begin
      @(posedge clk);
    end
    #1;
    chk(exp_q.size() == 0, t, exp_q.size(), 0);
    idle(2);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int hs0;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk(!fr_valid && !fr_stretch && !fifo_flush && !fifo_rd && !tx_locked,
        "R1 reset outputs", {fr_valid, fr_stretch, fifo_flush, fifo_rd, tx_locked}, 0);

    // R2 immediate mode
    wr(2'd1, 8'd3);
    expect_item(2'd0, 8'h11, "R2 byte0");
    expect_item(2'd0, 8'h22, "R2 byte1");
    expect_item(2'd1, 8'h33, "R2 last");
    push(8'h11); push(8'h22); push(8'h33);
    drain("R2 frame drained");

    // R5 backpressure
    fr_ready = 1'b0;
    wr(2'd1, 8'd4);
    expect_item(2'd0, 8'h41, "R5 byte0");
    expect_item(2'd0, 8'h42, "R5 byte1");
    expect_item(2'd0, 8'h43, "R5 byte2");
    expect_item(2'd1, 8'h44, "R5 last");
    push(8'h41); push(8'h42); push(8'h43); push(8'h44);
    idle(6);
    chk(fr_valid && fr_data == 8'h41 && fr_op == 2'd0, "R5 held item",
        {fr_valid, fr_op, fr_data}, {1'b1, 2'd0, 8'h41});
    for (int i = 0; i < 12; i++) begin
      fr_ready = ~fr_ready;
      idle(1);
    end
    fr_ready = 1'b1;
    drain("R5 frame drained");

    // R3 deferred mode waits for start
    wr(2'd0, 8'h01);
    wr(2'd1, 8'd4);
    push(8'h51); push(8'h52); push(8'h53); push(8'h54);
    hs0 = n_hs;
    idle(10);
    chk(n_hs == hs0 && !fr_valid && wp - rp == 7'd4, "R3 no send before start",
        n_hs - hs0, 0);
    expect_item(2'd0, 8'h51, "R3 byte0");
    expect_item(2'd0, 8'h52, "R3 byte1");
    expect_item(2'd0, 8'h53, "R3 byte2");
    expect_item(2'd1, 8'h54, "R3 last");
    wr(2'd2, 8'h01);
    drain("R3 frame drained");

    // R4 start during a frame is dropped
    fr_ready = 1'b0;
    expect_item(2'd0, 8'h61, "R4 byte0");
    expect_item(2'd0, 8'h62, "R4 byte1");
    expect_item(2'd0, 8'h63, "R4 byte2");
    expect_item(2'd1, 8'h64, "R4 last");
    push(8'h61); push(8'h62); push(8'h63); push(8'h64);
    wr(2'd2, 8'h01);
    idle(3);
    wr(2'd2, 8'h01);
    fr_ready = 1'b1;
    drain("R4 first frame drained");
    push(8'h65); push(8'h66); push(8'h67); push(8'h68);
    hs0 = n_hs;
    idle(12);
    chk(n_hs == hs0 && wp - rp == 7'd4, "R4 stale start ignored", n_hs - hs0, 0);
    expect_item(2'd0, 8'h65, "R4 byte0b");
    expect_item(2'd0, 8'h66, "R4 byte1b");
    expect_item(2'd0, 8'h67, "R4 byte2b");
    expect_item(2'd1, 8'h68, "R4 lastb");
    wr(2'd2, 8'h01);
    drain("R4 second frame drained");

    // R6 underrun
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd5);
    expect_item(2'd0, 8'h71, "R6 byte0");
    expect_item(2'd0, 8'h72, "R6 byte1");
    expect_item(2'd2, 8'h00, "R6 abort close");
    push(8'h71); push(8'h72);
    drain("R6 abort drained");
    chk(tx_locked, "R6 lock raised", tx_locked, 1);

    // R7 locked: nothing read or sent
    push(8'h81); push(8'h82); push(8'h83);
    hs0 = n_hs;
    idle(10);
    chk(n_hs == hs0 && wp - rp == 7'd3 && !fr_valid, "R7 locked no send",
        wp - rp, 3);

    // R8 order: resume then flush
    rd_resume();
    idle(4);
    chk(tx_locked, "R8 resume alone", tx_locked, 1);
    wr(2'd2, 8'h02);
    idle(4);
    chk(!tx_locked && fifo_empty, "R8 unlocked after flush", tx_locked, 0);
    wr(2'd1, 8'd2);
    expect_item(2'd0, 8'h91, "R8 byte0");
    expect_item(2'd1, 8'h92, "R8 last");
    push(8'h91); push(8'h92);
    drain("R8 frame after recovery");

    // R8 order: stale resume, underrun, flush, resume
    rd_resume();
    idle(2);
    wr(2'd1, 8'd3);
    expect_item(2'd0, 8'hA1, "R8 byte0c");
    expect_item(2'd2, 8'h00, "R8 abort c");
    push(8'hA1);
    drain("R8 second underrun");
    chk(tx_locked, "R8 relocked", tx_locked, 1);
    wr(2'd2, 8'h02);
    idle(4);
    chk(tx_locked, "R8 flush alone", tx_locked, 1);
    rd_resume();
    idle(4);
    chk(!tx_locked, "R8 unlocked after resume", tx_locked, 0);

    // R9 stretch instead of underrun
    wr(2'd0, 8'h02);
    wr(2'd1, 8'd3);
    expect_item(2'd0, 8'hB1, "R9 byte0");
    push(8'hB1);
    idle(8);
    chk(fr_stretch && !tx_locked && exp_q.size() == 0 && !fr_valid,
        "R9 stretch held", {fr_stretch, tx_locked}, 2'b10);
    expect_item(2'd0, 8'hB2, "R9 byte1");
    expect_item(2'd1, 8'hB3, "R9 last");
    push(8'hB2); push(8'hB3);
    drain("R9 frame resumed");
    chk(!fr_stretch && !tx_locked, "R9 stretch released", fr_stretch, 0);

    finish_run();
  end
endmodule